// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects sixteen external interrupt request pins, turns each into a pending status flag, and presents one winning request to a CPU. Each pin is first brought into the clock domain through a two-stage synchroniser. A 2-bit sense field per pin then selects the condition that sets the pin's flag: low level, falling edge or rising edge. A flag only requests service when its enable bit is set. Among the enabled pending pins, the one with the highest 3-bit priority level wins, and its number and level are driven to the CPU.

Software reaches the block through a simple synchronous register bus. The bus has a halfword data path, a 3-bit halfword register index and two byte-lane enables. Reads are combinational, and all writes take effect at the next clock edge. Software clears a status flag by writing zero to it. The write counts only if the flag has been read as one since it was last set, so a stale write cannot drop a request that software has not yet seen.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all eight registers read 0, every sense field selects low level, and `irq_req_o`, `irq_id_o` and `irq_lvl_o` are all 0.
- R2: Register index 0 holds the sense fields of pins 0..7 and index 1 holds those of pins 8..15. Pin n uses bits 2*(n mod 8)+1 : 2*(n mod 8). Code 0 is low level, 1 is falling edge, 2 is rising edge, and 3 never sets the flag.
- R3: Each pin passes through a two-flop synchroniser. For an edge or level that the first clock edge samples, the flag (and any request it causes) is present after the third edge, counting that first edge.
- R4: In low-level mode the flag is set on every clock while the synchronised pin is low, so a clearing write made during that time leaves the flag at 1.
- R5: Register index 2 holds the enable bits, with bit n for pin n. The enable gates only the request. A flag is set whether or not its pin is enabled.
- R6: Register index 3 holds the status flags, with bit n for pin n. Writing 0 to a bit clears that flag only if the flag was read as 1 since it was last set. Writing 1 has no effect.
- R7: If a set condition and a valid clearing write fall in the same cycle, the flag stays 1.
- R8: Register indices 4..7 hold the priorities. Pin n sits in index 4 + n/4 at bits (3 - n mod 4)*4 + 2 : (3 - n mod 4)*4. The top bit of each nibble reads as 0.
- R9: `irq_req_o` is high when some pin has its flag, its enable and a nonzero level all set. `irq_id_o` and `irq_lvl_o` then give the pin with the highest level, with ties going to the lowest pin number. With no such pin, all three outputs are 0.
- R10: `bus_be_i[0]` writes bits 7:0 and `bus_be_i[1]` writes bits 15:8. Bytes whose lane enable is clear keep their old contents.
- R11: The outputs follow register state combinationally, so a register write changes the request in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 16 | External request pins, asynchronous |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Halfword register index |
| bus_be_i | input | 2 | Byte-lane write enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the indexed register |
| irq_req_o | output | 1 | A qualifying request is present |
| irq_id_o | output | 4 | Number of the winning pin |
| irq_lvl_o | output | 3 | Priority level of the winning pin |

## Verification
Directed pin waveforms are applied to one pin in each sense mode: a one-cycle low pulse, a held low level and a low-then-high transition. These show that falling, rising, level and disabled detection each react to their own condition. The request output is sampled cycle by cycle to pin down the synchroniser latency. Clearing writes are tried without a prior read, with data 1, while a level pin is still low, and in the same cycle as a new edge, which tells the read-arming rule apart from a plain write-zero clear. Random sets of pending pins, enables and small priority levels, chosen so that ties and zero levels are common, are then compared against a bench model of the arbitration. This separates the highest-level choice from the lowest-number tie-break and from the rule that level 0 never wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_IRQ  = 16;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned ID_W   = $clog2(N_IRQ);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_OFF  = 2'd3
  } sense_e;

  localparam logic [ADDR_W-1:0] REG_SENSE_LO = 3'd0;
  localparam logic [ADDR_W-1:0] REG_ENABLE   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_PRIO0    = 3'd4;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   set_o
);
  // chain_q[SYNC_STAGES-1] is the synchronised pin, chain_q[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain_q;
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], pin_i};
  end

  assign cur  = chain_q[SYNC_STAGES-1];
  assign prev = chain_q[SYNC_STAGES];

  always_comb begin
    case (mode_i)
      SENSE_LOW:  set_o = ~cur;
      SENSE_FALL: set_o = prev & ~cur;
      SENSE_RISE: set_o = ~prev & cur;
      default:    set_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N     = 16,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned ID_W = $clog2(N)
) (
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  output logic                    req_o,
  output logic [ID_W-1:0]         id_o,
  output logic [LVL_W-1:0]        lvl_o
);
  always_comb begin
    lvl_o = '0;
    id_o  = '0;
    // strict compare keeps the lowest index on ties; level 0 never wins
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (lvl_i[i] > lvl_o)) begin
        lvl_o = lvl_i[i];
        id_o  = ID_W'(i);
      end
    end
  end

  assign req_o = (lvl_o != '0);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_pin_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_req_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  logic                         wr_en, rd_status;
  logic [N_IRQ-1:0][1:0]        sense_q;
  logic [N_IRQ-1:0]             en_q, flag_q, armed_q, set_ev, clr_fire;
  logic [N_IRQ-1:0][LVL_W-1:0]  prio_q;

  assign wr_en     = bus_req_i & bus_we_i;
  assign rd_status = bus_req_i & ~bus_we_i & (bus_addr_i == REG_STATUS);

  for (genvar n = 0; n < N_IRQ; n++) begin : g_pin
    localparam int unsigned SBIT  = 2 * (n % 8);
    localparam int unsigned SLANE = (n % 8) / 4;
    localparam int unsigned BLANE = n / 8;
    localparam int unsigned POFF  = (3 - (n % 4)) * 4;
    localparam int unsigned PLANE = POFF / 8;
    localparam logic [ADDR_W-1:0] SADDR = REG_SENSE_LO + ADDR_W'(n / 8);
    localparam logic [ADDR_W-1:0] PADDR = REG_PRIO0 + ADDR_W'(n / 4);

    sense_e           sense_r;
    logic             en_r, flag_r, armed_r;
    logic [LVL_W-1:0] prio_r;

    irq_pin_detect #(.SYNC_STAGES(2)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (irq_pin_i[n]),
      .mode_i (sense_r),
      .set_o  (set_ev[n])
    );

    // a clear needs a prior read-as-one and loses to a simultaneous set
    assign clr_fire[n] = wr_en && (bus_addr_i == REG_STATUS) && bus_be_i[BLANE]
                         && !bus_wdata_i[n] && armed_r && !set_ev[n];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sense_r <= SENSE_LOW;
        en_r    <= 1'b0;
        prio_r  <= '0;
        flag_r  <= 1'b0;
        armed_r <= 1'b0;
      end else begin
        if (wr_en && bus_addr_i == SADDR && bus_be_i[SLANE])
          sense_r <= sense_e'(bus_wdata_i[SBIT +: 2]);
        if (wr_en && bus_addr_i == REG_ENABLE && bus_be_i[BLANE])
          en_r <= bus_wdata_i[n];
        if (wr_en && bus_addr_i == PADDR && bus_be_i[PLANE])
          prio_r <= bus_wdata_i[POFF +: LVL_W];
        flag_r <= set_ev[n] | (flag_r & ~clr_fire[n]);
        if (set_ev[n] || clr_fire[n])    armed_r <= 1'b0;
        else if (rd_status && flag_r)    armed_r <= 1'b1;
      end
    end

    assign sense_q[n] = sense_r;
    assign en_q[n]    = en_r;
    assign prio_q[n]  = prio_r;
    assign flag_q[n]  = flag_r;
    assign armed_q[n] = armed_r;
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int n = 0; n < N_IRQ; n++) begin
      if (bus_addr_i == REG_SENSE_LO + ADDR_W'(n / 8))
        bus_rdata_o[2 * (n % 8) +: 2] = sense_q[n];
      if (bus_addr_i == REG_ENABLE) bus_rdata_o[n] = en_q[n];
      if (bus_addr_i == REG_STATUS) bus_rdata_o[n] = flag_q[n];
      if (bus_addr_i == REG_PRIO0 + ADDR_W'(n / 4))
        bus_rdata_o[(3 - (n % 4)) * 4 +: LVL_W] = prio_q[n];
    end
  end

  irq_arbiter #(.N(N_IRQ), .LVL_W(LVL_W)) u_arb (
    .pend_i (flag_q & en_q),
    .lvl_i  (prio_q),
    .req_o  (irq_req_o),
    .id_o   (irq_id_o),
    .lvl_o  (irq_lvl_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IRQ-1:0]  flag_i,
  input logic [N_IRQ-1:0]  en_i,
  input logic [N_IRQ-1:0]  armed_i,
  input logic [N_IRQ-1:0]  set_i,
  input logic              req_i,
  input logic [ID_W-1:0]   id_i,
  input logic [LVL_W-1:0]  lvl_i
);
  assert_winner_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (flag_i[id_i] && en_i[id_i] && lvl_i != '0));

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (id_i == '0 && lvl_i == '0));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
    assert_rise_from_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[i]) |-> $past(set_i[i]));

    assert_unarmed_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && !armed_i[i]) |=> flag_i[i]);

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_i[i]);
  end
endmodule

bind ext_irq_ctrl irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .flag_i  (flag_q),
  .en_i    (en_q),
  .armed_i (armed_q),
  .set_i   (set_ev),
  .req_i   (irq_req_o),
  .id_i    (irq_id_o),
  .lvl_i   (irq_lvl_o)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_pin_i = 16'hFFFF;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [1:0]  bus_be_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_req_o;
  logic [3:0]  irq_id_o;
  logic [2:0]  irq_lvl_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  ext_irq_ctrl i_ext_irq_ctrl (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // bench model
  logic [15:0] m_flag = '0, m_en = '0;
  logic [15:0] m_prio [4];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0; bus_be_i = '0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    check(tag, {16'h0, d}, {16'h0, exp});
  endtask

  function automatic logic [7:0] model_arb();
    logic [2:0] best = 0; logic [3:0] id = 0;
    for (int i = 0; i < 16; i++) begin
      logic [2:0] l = 3'((m_prio[i / 4] >> ((3 - i % 4) * 4)) & 16'h7);
      if (m_flag[i] && m_en[i] && l > best) begin best = l; id = 4'(i); end
    end
    return {(best != 0), id, best};
  endfunction

  task automatic out_chk(string tag);
    logic [7:0] e = model_arb();
    check(tag, {24'h0, irq_req_o, irq_id_o, irq_lvl_o}, {24'h0, e});
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    wait_neg(3);
    rst_ni = 1;
    wait_neg(2);

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reg reset", 3'(a), 16'h0);
    check("R1 no request", {29'h0, irq_req_o, irq_lvl_o[1:0]}, 32'h0);

    // R10 / R5: byte lanes on enable register
    bus_wr(3'd2, 16'hFFFF, 2'b01);
    rd_chk("R10 low lane only", 3'd2, 16'h00FF);
    bus_wr(3'd2, 16'hA5A5, 2'b10);
    rd_chk("R10 high lane only", 3'd2, 16'hA5FF);
    bus_wr(3'd2, 16'h0000, 2'b11);

    // R8: priority layout, top nibble bit reads 0
    bus_wr(3'd7, 16'hFFFF, 2'b11);
    rd_chk("R8 nibble top bit zero", 3'd7, 16'h7777);
    bus_wr(3'd7, 16'h0000, 2'b11);

    // R2: pin2 low, pin5 fall, pin6 rise, pin7 off
    bus_wr(3'd0, 16'hE400, 2'b11);
    rd_chk("R2 sense readback", 3'd0, 16'hE400);
    bus_wr(3'd2, 16'h0064, 2'b11);  // enable pins 2,5,6
    bus_wr(3'd5, 16'h0300, 2'b11);  // pin5 level 3

    // R3: falling edge latency on pin5
    @(negedge clk_i); irq_pin_i[5] = 0;
    @(negedge clk_i); irq_pin_i[5] = 1;
    @(negedge clk_i);
    check("R3 not yet after two edges", {31'h0, irq_req_o}, 32'h0);
    @(negedge clk_i);
    check("R3 request after third edge", {24'h0, irq_req_o, irq_id_o, irq_lvl_o}, {24'h0, 1'b1, 4'd5, 3'd3});
    wait_neg(3);
    check("R3 edge flag latched", {31'h0, irq_req_o}, 32'h1);

    // R6: clear rules
    bus_wr(3'd3, 16'h0000, 2'b11);
    check("R6 clear without read ignored", {31'h0, irq_req_o}, 32'h1);
    rd_chk("R6 status one", 3'd3, 16'h0020);
    bus_wr(3'd3, 16'hFFFF, 2'b11);
    rd_chk("R6 write one no effect", 3'd3, 16'h0020);
    bus_wr(3'd3, 16'h0000, 2'b01);
    rd_chk("R6 armed clear", 3'd3, 16'h0000);
    check("R11 request drops after clear", {31'h0, irq_req_o}, 32'h0);

    // R7: set and clear in same cycle
    @(negedge clk_i); irq_pin_i[5] = 0;
    @(negedge clk_i); irq_pin_i[5] = 1;
    wait_neg(3);
    rd_chk("R7 setup read", 3'd3, 16'h0020);
    @(negedge clk_i); irq_pin_i[5] = 0;
    @(negedge clk_i); irq_pin_i[5] = 1;
    bus_wr(3'd3, 16'h0000, 2'b11);
    rd_chk("R7 set wins", 3'd3, 16'h0020);
    bus_wr(3'd3, 16'h0000, 2'b11);
    rd_chk("R7 later clear", 3'd3, 16'h0000);

    // R4: low level on pin2
    bus_wr(3'd4, 16'h0050, 2'b11);  // pin2 level 5
    @(negedge clk_i); irq_pin_i[2] = 0;
    wait_neg(3);
    check("R4 level request", {24'h0, irq_req_o, irq_id_o, irq_lvl_o}, {24'h0, 1'b1, 4'd2, 3'd5});
    rd_chk("R4 status while low", 3'd3, 16'h0004);
    bus_wr(3'd3, 16'h0000, 2'b11);
    rd_chk("R4 clear while low ignored", 3'd3, 16'h0004);
    irq_pin_i[2] = 1;
    wait_neg(3);
    rd_chk("R4 flag held after release", 3'd3, 16'h0004);
    bus_wr(3'd3, 16'h0000, 2'b11);
    rd_chk("R4 clear after release", 3'd3, 16'h0000);

    // R2: rising edge on pin6
    bus_wr(3'd5, 16'h0320, 2'b11);
    @(negedge clk_i); irq_pin_i[6] = 0;
    wait_neg(4);
    rd_chk("R2 rise mode ignores fall", 3'd3, 16'h0000);
    irq_pin_i[6] = 1;
    wait_neg(3);
    rd_chk("R2 rise mode sets", 3'd3, 16'h0040);
    bus_wr(3'd3, 16'h0000, 2'b11);
    rd_chk("R2 rise flag cleared", 3'd3, 16'h0000);

    // R2: code 3 on pin7 never sets
    @(negedge clk_i); irq_pin_i[7] = 0;
    wait_neg(4);
    irq_pin_i[7] = 1;
    wait_neg(3);
    rd_chk("R2 off mode", 3'd3, 16'h0000);

    // R5: flag sets on a disabled pin without a request
    bus_wr(3'd1, 16'h5555, 2'b11);
    bus_wr(3'd6, 16'h7000, 2'b11);  // pin8 level 7, not enabled
    @(negedge clk_i); irq_pin_i[8] = 0;
    @(negedge clk_i); irq_pin_i[8] = 1;
    wait_neg(3);
    check("R5 disabled no request", {31'h0, irq_req_o}, 32'h0);
    rd_chk("R5 disabled still flags", 3'd3, 16'h0100);
    bus_wr(3'd3, 16'h0000, 2'b10);
    rd_chk("R5 cleared", 3'd3, 16'h0000);

    // R9: random arbitration, all falling edge
    bus_wr(3'd0, 16'h5555, 2'b11);
    m_flag = '0;
    for (int it = 0; it < 60; it++) begin
      logic [15:0] p, msk;
      m_en = 16'($urandom);
      bus_wr(3'd2, m_en, 2'b11);
      for (int w = 0; w < 4; w++) begin
        m_prio[w] = '0;
        for (int j = 0; j < 4; j++) m_prio[w][j * 4 +: 3] = 3'($urandom % 4);
        bus_wr(3'(4 + w), m_prio[w], 2'b11);
      end
      p = 16'($urandom) & 16'($urandom);
      @(negedge clk_i); irq_pin_i = ~p;
      @(negedge clk_i); irq_pin_i = 16'hFFFF;
      wait_neg(3);
      m_flag |= p;
      out_chk("R9 arbitration after set");
      rd_chk("R6 random status", 3'd3, m_flag);
      msk = 16'($urandom);
      bus_wr(3'd3, ~msk, 2'b11);
      m_flag &= ~msk;
      out_chk("R9 arbitration after clear");
    end

    // R9: level zero never requests
    for (int w = 0; w < 4; w++) bus_wr(3'(4 + w), 16'h0000, 2'b11);
    bus_wr(3'd2, 16'hFFFF, 2'b11);
    @(negedge clk_i); irq_pin_i = 16'h0000;
    @(negedge clk_i); irq_pin_i = 16'hFFFF;
    wait_neg(3);
    check("R9 level zero no request", {28'h0, irq_req_o, irq_lvl_o}, 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule